// File: doc/BRIEF.md
# Double-Buffered Quad Converter Register Interface

This block is the digital front end of a four-channel converter with a parallel data port. Each channel has two register levels: a staging register and an output register. A write, made by holding the chip select low and giving a rising edge on the write strobe, places the data word into the staging register of the channel picked by a two-bit address. The channel outputs do not change until the load input copies every staging register into its output register. Because all four copies happen on the same clock edge, all the channel outputs change together.

The strobes are sampled on a system clock, and the write edge is found by comparing the strobe with its value on the previous clock. A power-on reset and an asynchronous clear set both register levels to zero. The clear takes effect at once. It is released through a short synchronizer, so the first write edge after the release is seen cleanly. A power-down input is shared by all channels and is passed through to a status output.

The data width is a parameter. The intended values are 8, 10 and 12 bits.

Top module: `quadDacRegs`

## Requirements
- R1: While `rstN` is low, and after it is released, every bit of `dacOut` is zero until a write and a load have both occurred.
- R2: A rising edge of `wrN`, seen at a clock edge while `csN` is low, stores `dataIn` into the staging register selected by `addr`. While `loadN` is high, `dacOut` does not change.
- R3: `addr` value 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel k appears on `dacOut[k*DATA_W +: DATA_W]`.
- R4: At every clock edge where `loadN` is low, all four output registers take their staging values on that same edge.
- R5: While `loadN` is held low, a write reaches `dacOut` on the same clock edge that updates the staging register.
- R6: A rising edge of `wrN` while `csN` is high is ignored, and no register changes.
- R7: Holding `wrN` high with `csN` low, without a new low-to-high transition, performs no further write, even if `dataIn` changes.
- R8: Driving `clrN` low zeroes all staging and output registers without waiting for a clock edge.
- R9: Clear overrides write and load while `clrN` is low, and for the first `SYNC_STAGES` clock edges after `clrN` rises. A write edge at any later clock edge is accepted.
- R10: `pdOut` always equals `pdIn`, and changing `pdIn` leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all strobes |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| clrN | input | 1 | Clear, active low, asserts asynchronously and releases synchronously |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe; a rising edge commits the write |
| addr | input | 2 | Channel select for writes |
| dataIn | input | DATA_W | Data word for writes |
| loadN | input | 1 | Load, active low, level-sensitive |
| pdIn | input | 1 | Shared power-down request |
| dacOut | output | 4*DATA_W | Output registers, channel A in the lowest bits |
| pdOut | output | 1 | Power-down status |

## Verification
A table of writes and loads fills different channels between loads. This shows whether a write stays hidden until the load, and whether one load moves several channels at once. Writes with chip select high are placed among valid ones, so a dropped write is told apart from a wrong address decode.

Directed tests cover several cases:
- A write made while load is held low, which must pass straight through.
- The write strobe held high while the data changes, which must not write again.
- A clear applied between clock edges.
- A write edge that falls inside the clear-release window, and one that falls just after it.
- A toggle of power-down, which must leave the outputs unchanged.

// File: rtl/quadDacPkg.sv
package quadDacPkg;
  localparam int CH_COUNT = 4;
  localparam int ADDR_W   = $clog2(CH_COUNT);

  typedef struct packed {
    logic [CH_COUNT-1:0] wrEn;
    logic                loadAll;
  } strobes_t;
endpackage

// File: rtl/quadDacRstSync.sv
module quadDacRstSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic clrN,
  output logic regRstN
);
  logic              holdN;
  logic [SYNC_STAGES-1:0] chain;

  // Either source asserts at once; release is walked through the chain
  assign holdN = porN & clrN;

  always_ff @(posedge clk or negedge holdN) begin
    if (!holdN) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-2:0], 1'b1};
  end

  assign regRstN = chain[SYNC_STAGES-1];
endmodule

// File: rtl/quadDacCtrl.sv
module quadDacCtrl
  import quadDacPkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic              regRstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              loadN,
  output strobes_t          strobes
);
  logic wrPrev;
  logic wrRise;
  logic wrValid;

  // Edge tracker runs during clear so that the first edge after release is seen
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) wrPrev <= 1'b1;
    else       wrPrev <= wrN;
  end

  assign wrRise  = wrN & ~wrPrev;
  assign wrValid = wrRise & ~csN & regRstN;

  genvar ch;
  generate
    for (ch = 0; ch < CH_COUNT; ch++) begin : g_dec
      assign strobes.wrEn[ch] = wrValid && (addr == ADDR_W'(ch));
    end
  endgenerate

  assign strobes.loadAll = ~loadN & regRstN;
endmodule

// File: rtl/quadDacPath.sv
module quadDacPath
  import quadDacPkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                       clk,
  input  logic                       regRstN,
  input  strobes_t                   strobes,
  input  logic [DATA_W-1:0]          dataIn,
  output logic [CH_COUNT*DATA_W-1:0] dacOut
);
  genvar ch;
  generate
    for (ch = 0; ch < CH_COUNT; ch++) begin : g_ch
      logic [DATA_W-1:0] stageQ;
      logic [DATA_W-1:0] stageD;
      logic [DATA_W-1:0] outQ;

      assign stageD = strobes.wrEn[ch] ? dataIn : stageQ;

      always_ff @(posedge clk or negedge regRstN) begin
        if (!regRstN) stageQ <= '0;
        else          stageQ <= stageD;
      end

      // Loading from stageD makes a held-low load transparent to writes
      always_ff @(posedge clk or negedge regRstN) begin
        if (!regRstN)             outQ <= '0;
        else if (strobes.loadAll) outQ <= stageD;
      end

      assign dacOut[ch*DATA_W +: DATA_W] = outQ;
    end
  endgenerate
endmodule

// File: rtl/quadDacRegs.sv
module quadDacRegs
  import quadDacPkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clrN,
  input  logic                       csN,
  input  logic                       wrN,
  input  logic [1:0]                 addr,
  input  logic [DATA_W-1:0]          dataIn,
  input  logic                       loadN,
  input  logic                       pdIn,
  output logic [CH_COUNT*DATA_W-1:0] dacOut,
  output logic                       pdOut
);
  logic     regRstN;
  strobes_t strobes;

  quadDacRstSync #(.SYNC_STAGES(SYNC_STAGES)) i_rstSync (
    .clk     (clk),
    .porN    (rstN),
    .clrN    (clrN),
    .regRstN (regRstN)
  );

  quadDacCtrl i_ctrl (
    .clk     (clk),
    .porN    (rstN),
    .regRstN (regRstN),
    .csN     (csN),
    .wrN     (wrN),
    .addr    (addr),
    .loadN   (loadN),
    .strobes (strobes)
  );

  quadDacPath #(.DATA_W(DATA_W)) i_path (
    .clk     (clk),
    .regRstN (regRstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .dacOut  (dacOut)
  );

  assign pdOut = pdIn;
endmodule

// File: rtl/quadDacChk.sv
module quadDacChk #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrN,
  input logic              csN,
  input logic              wrN,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] dataIn,
  input logic              loadN,
  input logic [4*DATA_W-1:0] dacOut
);
  localparam int CNT_W = $clog2(SYNC_STAGES + 1) + 1;

  logic              relN;
  logic [CNT_W-1:0]  relCnt;
  logic              ready;
  logic [DATA_W-1:0] chView [4];

  assign relN = rstN & clrN;

  always_ff @(posedge clk or negedge relN) begin
    if (!relN)                              relCnt <= '0;
    else if (relCnt < CNT_W'(SYNC_STAGES))  relCnt <= relCnt + 1'b1;
  end

  assign ready = (relCnt >= CNT_W'(SYNC_STAGES));

  genvar k;
  generate
    for (k = 0; k < 4; k++) begin : g_view
      assign chView[k] = dacOut[k*DATA_W +: DATA_W];
    end
  endgenerate

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_ZERO: assert (dacOut == '0); // R1
    end
  end

  AST_HIDDEN_WRITE: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    loadN |=> $stable(dacOut)); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> (dacOut == '0)); // R8

  AST_CS_IGNORE: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    (csN && !loadN && !$past(loadN)) |=> $stable(dacOut)); // R6

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    (ready && !loadN && !csN && wrN && !$past(wrN)) |=> (chView[$past(addr)] == $past(dataIn))); // R5
endmodule

bind quadDacRegs quadDacChk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_quadDacChk (
  .clk    (clk),
  .rstN   (rstN),
  .clrN   (clrN),
  .csN    (csN),
  .wrN    (wrN),
  .addr   (addr),
  .dataIn (dataIn),
  .loadN  (loadN),
  .dacOut (dacOut)
);

// File: tb/test_quadDacRegs.sv
`timescale 1ns/100ps
module test_quadDacRegs;
  localparam int DW = 12;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rstN, clrN, csN, wrN, loadN, pdIn;
  logic [1:0]    addr;
  logic [DW-1:0] dataIn;
  logic [4*DW-1:0] dacOut;
  logic          pdOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quadDacRegs #(.DATA_W(DW), .SYNC_STAGES(2)) i_quadDacRegs (
    .clk(clk), .rstN(rstN), .clrN(clrN), .csN(csN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .loadN(loadN), .pdIn(pdIn), .dacOut(dacOut), .pdOut(pdOut)
  );

  // {isLoad, csN, addr, data, expected dacOut = {D,C,B,A}}
  localparam logic [63:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 12'h123, 48'h000_000_000_000},
    {1'b0, 1'b0, 2'd1, 12'h456, 48'h000_000_000_000},
    {1'b0, 1'b1, 2'd2, 12'h789, 48'h000_000_000_000},
    {1'b1, 1'b1, 2'd0, 12'h000, 48'h000_000_456_123},
    {1'b0, 1'b0, 2'd3, 12'hFFF, 48'h000_000_456_123},
    {1'b0, 1'b0, 2'd0, 12'hABC, 48'h000_000_456_123},
    {1'b1, 1'b1, 2'd0, 12'h000, 48'hFFF_000_456_ABC},
    {1'b0, 1'b0, 2'd2, 12'h001, 48'hFFF_000_456_ABC},
    {1'b1, 1'b1, 2'd0, 12'h000, 48'hFFF_001_456_ABC}
  };

  task automatic check(input string tag, input logic [4*DW-1:0] act, input logic [4*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write commits on the second rising edge
  task automatic doWrite(input logic cs, input logic [1:0] a, input logic [DW-1:0] d);
    csN = cs; addr = a; dataIn = d; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); csN = 1'b1;
  endtask

  task automatic doLoad();
    loadN = 1'b0;
    @(negedge clk); loadN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clrN = 1'b1; csN = 1'b1; wrN = 1'b1; loadN = 1'b1;
    pdIn = 1'b0; addr = 2'd0; dataIn = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", dacOut, '0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", dacOut, '0);

    // Table walk: R2 hidden writes, R3 mapping, R4 joint load, R6 ignored select
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][63]) doLoad();
      else            doWrite(VEC[i][62], VEC[i][61:60], VEC[i][59:48]);
      check($sformatf("R2/R3/R4/R6 vector %0d", i), dacOut, VEC[i][47:0]);
    end

    // R5: load held low passes a write straight through
    loadN = 1'b0;
    @(negedge clk);
    doWrite(1'b0, 2'd1, 12'h5A5);
    check("R5 transparent write", dacOut, 48'hFFF_001_5A5_ABC);

    // R6: ignored while load is low
    doWrite(1'b1, 2'd0, 12'h111);
    check("R6 deselected write", dacOut, 48'hFFF_001_5A5_ABC);

    // R7: strobe held high, data changes, no second write
    csN = 1'b0; addr = 2'd3; wrN = 1'b1;
    for (int j = 0; j < 3; j++) begin
      dataIn = DW'(12'h700 + j);
      @(negedge clk);
    end
    csN = 1'b1;
    @(negedge clk);
    check("R7 no rewrite", dacOut, 48'hFFF_001_5A5_ABC);

    // R10: power-down passes through and leaves registers alone
    pdIn = 1'b1;
    #0.5;
    check("R10 pdOut high", {47'd0, pdOut}, 48'd1);
    repeat (2) @(negedge clk);
    check("R10 regs kept", dacOut, 48'hFFF_001_5A5_ABC);
    pdIn = 1'b0;
    #0.5;
    check("R10 pdOut low", {47'd0, pdOut}, 48'd0);
    @(negedge clk);

    // R8: clear between clock edges
    #1 clrN = 1'b0;
    #1 check("R8 async clear", dacOut, '0);
    @(negedge clk);

    // R9: write during clear is dropped
    doWrite(1'b0, 2'd0, 12'h321);
    check("R9 write in clear", dacOut, '0);

    // R9: write edge at second edge after release is dropped
    clrN = 1'b1; csN = 1'b0; addr = 2'd1; dataIn = 12'h4C4; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); csN = 1'b1;
    check("R9 release window", dacOut, '0);

    // R9: later write accepted (load still low)
    doWrite(1'b0, 2'd1, 12'h4C4);
    check("R9 after release", dacOut, 48'h000_000_4C4_000);
    loadN = 1'b1;
    @(negedge clk);

    // R1: power-on reset again zeroes both levels
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    doLoad();
    check("R1 reset clears staging", dacOut, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule